// File: doc/BRIEF.md
# Flagged Sensor Output Word Bank

This block keeps the most recent sample of every measurement channel and presents each one as a 16-bit word that a register-read port can fetch. An update strobe loads all channels together, so the bank always holds one coherent sample set.

Each word carries two flags in its top bits. One is an unread-data indication: it rises when a sample set is loaded and falls when software reads any channel word. The other is an error summary: the OR of an external status vector. The data field sits in the low bits, right-justified. Channels configured as 12-bit force the two upper field bits to zero.

Data bits pass through unchanged, whether the channel is unsigned binary or two's complement. The full status vector can be read at its own address.

Top module: `sensor_out_bank`

## Requirements
- R1: After reset every channel word, the unread flag and the read data output are all zero.
- R2: A cycle with `upd_i` high loads every channel from `samp_i` and sets the shared unread flag. Channel i occupies `samp_i[14*i+13:14*i]`.
- R3: A read of a channel address (0 to NUM_CH-1) clears the shared unread flag, unless the same cycle carries an update. When an update and a read share a cycle, the update wins: the flag ends set and the new data is held.
- R4: The read data returns, one cycle after `rd_en_i`, a word laid out as follows: bit 15 is the unread flag as it stood before the read, bit 14 is the OR of `stat_i`, and bits 13:0 hold the channel data.
- R5: For a channel whose bit is set in NARROW_MASK (12-bit channel), bits 13:12 of its word read as zero. Bits 11:0 carry the 12-bit data.
- R6: Address NUM_CH returns `stat_i` zero-extended to 16 bits and leaves the unread flag unchanged.
- R7: Any address above NUM_CH returns 0x0000 and leaves the unread flag unchanged.
- R8: `rd_data_o` holds its value on cycles without `rd_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_i | input | 1 | Sample-set load strobe |
| samp_i | input | NUM_CH*14 | Packed incoming samples, channel 0 lowest |
| stat_i | input | STAT_W | Error/alarm status vector |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | 16 | Registered read word |

## Verification
Read data appears one clock edge after the request. An update or a read-clear changes the unread flag at that same edge, so the effect first shows in the word returned by the next read. The bench drives inputs on the falling edge, lets a single rising edge pass, and samples on the following falling edge. Its own model of the flag and the stored samples advances at exactly that edge, including in the cycle where an update and a read coincide.

// File: rtl/sensor_out_bank.sv
module sensor_out_bank #(
  parameter int NUM_CH = 8,
  parameter int STAT_W = 8,
  parameter int ADDR_W = 4,
  parameter logic [NUM_CH-1:0] NARROW_MASK = 8'h18
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd_i,
  input  logic [NUM_CH*14-1:0] samp_i,
  input  logic [STAT_W-1:0]    stat_i,
  input  logic                 rd_en_i,
  input  logic [ADDR_W-1:0]    rd_addr_i,
  output logic [15:0]          rd_data_o
);
  localparam int FW = 14;
  localparam int CH_AW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(NUM_CH);

  logic [FW-1:0] word_q [NUM_CH];
  logic [FW-1:0] word_d [NUM_CH];
  logic          nd_q;
  wire           hit_ch = rd_en_i && (rd_addr_i < STAT_A);
  wire           hit_st = rd_en_i && (rd_addr_i == STAT_A);
  wire           err    = |stat_i;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    if (NARROW_MASK[i]) begin : g_n
      assign word_d[i] = {2'b00, samp_i[i*FW +: FW-2]};
    end else begin : g_w
      assign word_d[i] = samp_i[i*FW +: FW];
    end
    always_ff @(posedge clk) begin
      if (!rst_n) word_q[i] <= '0;
      else if (upd_i) word_q[i] <= word_d[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) nd_q <= 1'b0;
    else if (upd_i) nd_q <= 1'b1;
    else if (hit_ch) nd_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data_o <= '0;
    else if (hit_ch) rd_data_o <= {nd_q, err, word_q[rd_addr_i[CH_AW-1:0]]};
    else if (hit_st) rd_data_o <= 16'(stat_i);
    else if (rd_en_i) rd_data_o <= '0;
  end

  a_r2_update_sets: assert property (@(posedge clk) disable iff (!rst_n)
    upd_i |=> nd_q);
  a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_ch && !upd_i) |=> !nd_q);
  a_r4_flag_bits: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ch |=> (rd_data_o[15] == $past(nd_q)) && (rd_data_o[14] == $past(err)));
  a_r5_narrow_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_ch && NARROW_MASK[rd_addr_i[CH_AW-1:0]]) |=> rd_data_o[13:12] == 2'b00);
  a_r6_status_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_st && !upd_i) |=> $stable(nd_q));
  a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && rd_addr_i > STAT_A) |=> rd_data_o == 16'h0000);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en_i && $past(rst_n)) |=> $stable(rd_data_o));
endmodule

// File: tb/test_sensor_out_bank.sv
module test_sensor_out_bank;
  localparam int NCH = 8;
  localparam logic [7:0] NARROW = 8'h18;
  logic clk = 0, rst_n = 0, upd = 0, rd_en = 0;
  logic [NCH*14-1:0] samp = '0;
  logic [7:0] stat = '0;
  logic [3:0] addr = '0;
  logic [15:0] rdata;
  int n_chk = 0, n_bad = 0;
  logic m_nd = 0;
  logic [13:0] m_w [NCH];

  always #5 clk = ~clk;

  sensor_out_bank i_sensor_out_bank (
    .clk(clk), .rst_n(rst_n), .upd_i(upd), .samp_i(samp), .stat_i(stat),
    .rd_en_i(rd_en), .rd_addr_i(addr), .rd_data_o(rdata));

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_ch(int c, logic nd);
    return {nd, |stat, m_w[c]};
  endfunction

  task automatic load(int seed);
    @(negedge clk);
    for (int i = 0; i < NCH; i++) begin
      samp[i*14 +: 14] = 14'(seed * 977 + i * 5431 + 14'h3000);
      m_w[i] = NARROW[i] ? {2'b00, samp[i*14 +: 12]} : samp[i*14 +: 14];
    end
    upd = 1;
    @(negedge clk);
    upd = 0;
    m_nd = 1;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a; rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    d = rdata;
  endtask

  task automatic t_reset;
    logic [15:0] d;
    chk("R1 out", rdata, 16'h0);
    rd(4'd0, d); chk("R1 ch0", d, 16'h0);
    rd(4'd7, d); chk("R1 ch7", d, 16'h0);
  endtask

  task automatic t_basic;
    logic [15:0] d;
    load(1);
    rd(4'd0, d); chk("R2 R4 first read", d, exp_ch(0, 1'b1));
    m_nd = 0;
    rd(4'd1, d); chk("R3 flag cleared", d, exp_ch(1, 1'b0));
    rd(4'd5, d); chk("R4 ch5", d, exp_ch(5, 1'b0));
  endtask

  task automatic t_narrow;
    logic [15:0] d;
    load(7);
    rd(4'd3, d); chk("R5 ch3", d, exp_ch(3, 1'b1));
    chk("R5 bits13:12", {14'h0, d[13:12]}, 16'h0);
    rd(4'd4, d); chk("R5 ch4", d, exp_ch(4, 1'b0));
  endtask

  task automatic t_status;
    logic [15:0] d;
    load(3);
    stat = 8'h24;
    rd(4'd8, d); chk("R6 status word", d, 16'h0024);
    rd(4'd9, d); chk("R7 unmapped 9", d, 16'h0);
    rd(4'd15, d); chk("R7 unmapped 15", d, 16'h0);
    rd(4'd2, d); chk("R6 R7 flag kept, R4 error", d, exp_ch(2, 1'b1));
    stat = 8'h00;
    rd(4'd2, d); chk("R4 error gone", d, exp_ch(2, 1'b0));
  endtask

  task automatic t_collide;
    logic [15:0] d, old;
    rd(4'd6, d);
    old = exp_ch(6, 1'b0);
    chk("R3 pre", d, old);
    @(negedge clk);
    for (int i = 0; i < NCH; i++) samp[i*14 +: 14] = 14'(i * 333 + 14'h155);
    upd = 1; rd_en = 1; addr = 4'd6;
    @(negedge clk);
    upd = 0; rd_en = 0;
    chk("R3 collide returns old", rdata, old);
    for (int i = 0; i < NCH; i++)
      m_w[i] = NARROW[i] ? {2'b00, samp[i*14 +: 12]} : samp[i*14 +: 14];
    rd(4'd6, d); chk("R3 update wins", d, exp_ch(6, 1'b1));
  endtask

  task automatic t_hold;
    logic [15:0] d;
    rd(4'd0, d);
    repeat (3) @(negedge clk);
    chk("R8 hold", rdata, d);
  endtask

  initial begin
    for (int i = 0; i < NCH; i++) m_w[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_basic;
    t_narrow;
    t_status;
    t_collide;
    t_hold;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule